// File: doc/BRIEF.md
# Converter Status and Error Tracker

This block keeps the 24-bit status word of a decimating sigma-delta converter back end. It turns per-cycle event strobes into sticky error flags: an overwrite of unread or partly read data, an overrange flag from the modulator, an accumulator saturation and a sustained out-of-range condition on the output samples. It also tracks whether the decimation filter has settled and echoes the current configuration fields. An active-low error pin mirrors the summary error bit, so several converters can share one error line.

Filter settling is tracked by a three-state machine. `ST_FILL` counts output samples after a restart. `ST_SETTLED` is the normal operating state. `ST_PWRDN` holds while power-down is requested. The transitions are:
- Any state goes to `ST_PWRDN` while `cfg_pwrdn` is high.
- `ST_PWRDN` goes to `ST_FILL` when power-down is released.
- `ST_FILL` goes to `ST_SETTLED` on the `SETTLE_LEN`-th output sample.
- `ST_FILL` and `ST_SETTLED` go back to `ST_FILL`, with the count cleared, on a sync request or when the bandwidth field or the test-select field differs from its value on the previous clock.

Reset puts the machine in `ST_FILL`. While the filter is not settled, the four error flags are frozen.

Top module: `conv_status_tracker`

## Requirements
- R1: Status bit 23 is the OR of bits 22, 21, 19 and 16. `err_n` is its inverse.
- R2: Bit 22 (overwrite) sets when `result_load` arrives while a previous result is still unread (bit 18 high) or while a data read is in progress (a `read_start` without a following `read_done`). A load after a completed read does not set it.
- R3: Bit 21 (modulator flag) sets on a clock edge where `mod_flag` is high.
- R4: Bit 19 (accumulator) sets on a clock edge where `acc_sat` is high.
- R5: Bit 16 (range) sets when `RUN_LEN` (default 4) consecutive loaded samples are all above +6,291,455 or all below −6,291,456, read as signed 24-bit values. A sample inside that range, or one outside it on the other side, restarts the run. Samples equal to the limits are in range.
- R6: Bit 17 (settled) is low after reset, while `cfg_pwrdn` is high, and after a sync request or a change of `cfg_bw` or `cfg_test_sel`. It goes high on the edge of the `SETTLE_LEN`-th (default 16) `result_load` counted in `ST_FILL`. Loads during power-down are not counted.
- R7: While bit 17 is low, bits 22, 21, 19 and 16 hold their value: events do not set them and a status read does not clear them.
- R8: Reset clears bits 23 to 16. While settled, `stat_rd_done` clears the error flags, but a set event in the same cycle wins over the clear.
- R9: Bit 18 (result pending) sets on `result_load` and clears on `read_done`.
- R10: The low bits echo the configuration: bit 11 is `cfg_pwrdn`, bit 10 is `cfg_test_sel`, bits 8:6 are `cfg_bw` and bits 4:0 are `cfg_gain`. Bits 20, 15:12, 9 and 5 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| result_load | input | 1 | Strobe: a new output sample is loaded |
| sample | input | 24 | Output sample being loaded, two's complement |
| read_start | input | 1 | Strobe: a data read has begun |
| read_done | input | 1 | Strobe: a data read has finished |
| stat_rd_done | input | 1 | Strobe: a status read has finished |
| mod_flag | input | 1 | Modulator overrange level, sampled each clock |
| acc_sat | input | 1 | Strobe: filter accumulator clipped |
| sync_req | input | 1 | Strobe: filter resynchronisation |
| cfg_pwrdn | input | 1 | Power-down request level |
| cfg_test_sel | input | 1 | Filter input selects test data |
| cfg_bw | input | 3 | Bandwidth / output rate field |
| cfg_gain | input | 5 | Front-end gain and input select field |
| status | output | 24 | Status word |
| err_n | output | 1 | Error output, active low |

## Verification
Some behaviours are checked by assertions on every cycle:
- The error flags hold while the filter is unsettled.
- The flags clear after a status read that comes with no event.
- Power-down or a restart drops the settled bit on the next edge.
- A rising overwrite flag always follows a load.
- The settle counter and the run counter stay within their bounds.

Other behaviours only the bench scenarios can show:
- The exact sample at which settling completes.
- The overwrite during a partly finished read.
- Range runs broken by an in-range sample or by a change of sign, and samples sitting exactly on the limits.
- A set event winning over a clear in the same cycle.

The behavioural reference model, compared every clock, covers the mixed sequences in between.

// File: rtl/cst_pkg.sv
package cst_pkg;
    typedef enum logic [1:0] {
        ST_FILL    = 2'd0,
        ST_SETTLED = 2'd1,
        ST_PWRDN   = 2'd2
    } settle_st_t;

    localparam int STATUS_W = 24;
    localparam int BW_W     = 3;
    localparam int GAIN_W   = 5;
    localparam int NFLAG    = 4;
endpackage

// File: rtl/cst_settle_fsm.sv
module cst_settle_fsm
    import cst_pkg::*;
#(
    parameter int SETTLE_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwrdn,
    input  logic restart,
    input  logic load,
    output logic settled
);
    localparam int CNT_W = (SETTLE_LEN > 1) ? $clog2(SETTLE_LEN) : 1;

    settle_st_t       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             last_load;

    assign last_load = load && (cnt_q == CNT_W'(SETTLE_LEN - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_FILL;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (pwrdn) begin
            st_d  = ST_PWRDN;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                ST_PWRDN: begin
                    st_d  = ST_FILL;
                    cnt_d = '0;
                end
                ST_FILL: begin
                    if (restart) begin
                        cnt_d = '0;
                    end else if (last_load) begin
                        st_d  = ST_SETTLED;
                        cnt_d = '0;
                    end else if (load) begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_SETTLED: begin
                    if (restart) begin
                        st_d  = ST_FILL;
                        cnt_d = '0;
                    end
                end
                default: begin
                    st_d  = ST_FILL;
                    cnt_d = '0;
                end
            endcase
        end
    end

    always_comb begin
        settled = (st_q == ST_SETTLED);
    end

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) < SETTLE_LEN);
    assert_pwrdn_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn |=> !settled);
    assert_restart_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !settled);
    assert_settle_on_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(settled) |-> $past(load));
endmodule

// File: rtl/cst_range_mon.sv
module cst_range_mon #(
    parameter int SAMPLE_W = 24,
    parameter int RUN_LEN  = 4,
    parameter int HI_LIM   = 6291455,
    parameter int LO_LIM   = -6291456
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                hit
);
    localparam int RUN_W = $clog2(RUN_LEN + 1);
    localparam logic signed [SAMPLE_W-1:0] HI_V = SAMPLE_W'(HI_LIM);
    localparam logic signed [SAMPLE_W-1:0] LO_V = SAMPLE_W'(LO_LIM);

    logic [RUN_W-1:0] run_q, run_d;
    logic             side_q, side_d;
    logic             above, below;

    assign above = $signed(sample) > HI_V;
    assign below = $signed(sample) < LO_V;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            side_q <= 1'b0;
        end else begin
            run_q  <= run_d;
            side_q <= side_d;
        end
    end

    always_comb begin
        run_d  = run_q;
        side_d = side_q;
        if (load) begin
            if (!above && !below) begin
                run_d = '0;
            end else if (run_q != '0 && side_q == above) begin
                run_d = (run_q == RUN_W'(RUN_LEN)) ? run_q : run_q + 1'b1;
            end else begin
                run_d  = RUN_W'(1);
                side_d = above;
            end
        end
    end

    assign hit = load && (above || below) && (run_d == RUN_W'(RUN_LEN));

    assert_run_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(run_q) <= RUN_LEN);
    assert_hit_after_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (run_q >= RUN_W'(RUN_LEN - 1)));
endmodule

// File: rtl/cst_err_flags.sv
module cst_err_flags
    import cst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             settled,
    input  logic             load,
    input  logic             read_start,
    input  logic             read_done,
    input  logic             stat_rd,
    input  logic             mod_flag,
    input  logic             acc_sat,
    input  logic             range_hit,
    output logic [NFLAG-1:0] flags,
    output logic             pending
);
    logic             reading_q;
    logic             ovwr_set;
    logic [NFLAG-1:0] set_v;

    assign ovwr_set = load && (pending || reading_q);
    assign set_v    = {ovwr_set, mod_flag, acc_sat, range_hit};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending   <= 1'b0;
            reading_q <= 1'b0;
        end else begin
            pending   <= load | (pending & ~read_done);
            reading_q <= read_start | (reading_q & ~read_done);
        end
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        logic cell_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q <= 1'b0;
            end else if (settled) begin
                cell_q <= set_v[i] | (cell_q & ~stat_rd);
            end
        end
        assign flags[i] = cell_q;
    end

    assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !settled |=> $stable(flags));
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && stat_rd && !load && !mod_flag && !acc_sat) |=> (flags == '0));
    assert_ovwr_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[3]) |-> $past(load));
    assert_acc_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[1]) |-> $past(acc_sat));
    assert_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> pending);
endmodule

// File: rtl/conv_status_tracker.sv
module conv_status_tracker
    import cst_pkg::*;
#(
    parameter int SETTLE_LEN = 16,
    parameter int RUN_LEN    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                result_load,
    input  logic [23:0]         sample,
    input  logic                read_start,
    input  logic                read_done,
    input  logic                stat_rd_done,
    input  logic                mod_flag,
    input  logic                acc_sat,
    input  logic                sync_req,
    input  logic                cfg_pwrdn,
    input  logic                cfg_test_sel,
    input  logic [BW_W-1:0]     cfg_bw,
    input  logic [GAIN_W-1:0]   cfg_gain,
    output logic [STATUS_W-1:0] status,
    output logic                err_n
);
    logic [BW_W-1:0]  bw_prev_q;
    logic             ts_prev_q;
    logic             cfg_change;
    logic             restart;
    logic             settled;
    logic             range_hit;
    logic             pending;
    logic [NFLAG-1:0] flags;
    logic             err_any;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bw_prev_q <= '0;
            ts_prev_q <= 1'b0;
        end else begin
            bw_prev_q <= cfg_bw;
            ts_prev_q <= cfg_test_sel;
        end
    end

    assign cfg_change = (cfg_bw != bw_prev_q) || (cfg_test_sel != ts_prev_q);
    assign restart    = sync_req || cfg_change;

    cst_settle_fsm #(.SETTLE_LEN(SETTLE_LEN)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwrdn   (cfg_pwrdn),
        .restart (restart),
        .load    (result_load),
        .settled (settled)
    );

    cst_range_mon #(.SAMPLE_W(24), .RUN_LEN(RUN_LEN)) u_range (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (result_load),
        .sample (sample),
        .hit    (range_hit)
    );

    cst_err_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .settled    (settled),
        .load       (result_load),
        .read_start (read_start),
        .read_done  (read_done),
        .stat_rd    (stat_rd_done),
        .mod_flag   (mod_flag),
        .acc_sat    (acc_sat),
        .range_hit  (range_hit),
        .flags      (flags),
        .pending    (pending)
    );

    assign err_any = |flags;
    assign err_n   = ~err_any;
    assign status  = {err_any, flags[3], flags[2], 1'b0, flags[1], pending, settled,
                      flags[0], 4'b0000, cfg_pwrdn, cfg_test_sel, 1'b0, cfg_bw,
                      1'b0, cfg_gain};

    assert_err_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_n) |-> $past(settled));
    assert_err_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_n) |-> $past(stat_rd_done));
endmodule

// File: tb/conv_status_tracker_tb.sv
module conv_status_tracker_tb;
    localparam int SETTLE = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        result_load = 1'b0;
    logic [23:0] sample = '0;
    logic        read_start = 1'b0, read_done = 1'b0, stat_rd_done = 1'b0;
    logic        mod_flag = 1'b0, acc_sat = 1'b0, sync_req = 1'b0;
    logic        cfg_pwrdn = 1'b0, cfg_test_sel = 1'b0;
    logic [2:0]  cfg_bw = 3'b010;
    logic [4:0]  cfg_gain = 5'b10110;
    logic [23:0] status;
    logic        err_n;

    int checks = 0;
    int fails  = 0;

    conv_status_tracker #(.SETTLE_LEN(SETTLE), .RUN_LEN(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .result_load(result_load), .sample(sample),
        .read_start(read_start), .read_done(read_done), .stat_rd_done(stat_rd_done),
        .mod_flag(mod_flag), .acc_sat(acc_sat), .sync_req(sync_req),
        .cfg_pwrdn(cfg_pwrdn), .cfg_test_sel(cfg_test_sel), .cfg_bw(cfg_bw),
        .cfg_gain(cfg_gain), .status(status), .err_n(err_n)
    );

    always #5 clk = ~clk;

    task automatic chk(string tag, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model: 0 fill, 1 settled, 2 power-down
    int       m_st, m_cnt, m_run;
    bit       m_side, m_ovwr, m_mflg, m_acc, m_drng, m_pend, m_rdg, m_pts;
    bit [2:0] m_pbw;

    task automatic model_step();
        int sv, nrun;
        bit above, below, hit, ovs, chg, ok, nside;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_run = 0; m_side = 0;
            m_ovwr = 0; m_mflg = 0; m_acc = 0; m_drng = 0;
            m_pend = 0; m_rdg = 0; m_pbw = 0; m_pts = 0;
            return;
        end
        ok = (m_st == 1);
        sv = int'($signed(sample));
        above = sv > 6291455;
        below = sv < -6291456;
        nrun = m_run; nside = m_side;
        if (result_load) begin
            if (!above && !below) nrun = 0;
            else if (m_run != 0 && m_side == above) nrun = (m_run == 4) ? 4 : m_run + 1;
            else begin nrun = 1; nside = above; end
        end
        hit = result_load && (above || below) && nrun == 4;
        ovs = result_load && (m_pend || m_rdg);
        if (ok) begin
            m_ovwr = ovs       | (m_ovwr & !stat_rd_done);
            m_mflg = mod_flag  | (m_mflg & !stat_rd_done);
            m_acc  = acc_sat   | (m_acc  & !stat_rd_done);
            m_drng = hit       | (m_drng & !stat_rd_done);
        end
        m_pend = result_load | (m_pend & !read_done);
        m_rdg  = read_start  | (m_rdg  & !read_done);
        chg = (cfg_bw != m_pbw) || (cfg_test_sel != m_pts);
        if (cfg_pwrdn) begin m_st = 2; m_cnt = 0; end
        else if (m_st == 2) begin m_st = 0; m_cnt = 0; end
        else if (sync_req || chg) begin m_st = 0; m_cnt = 0; end
        else if (m_st == 0 && result_load) begin
            if (m_cnt == SETTLE - 1) begin m_st = 1; m_cnt = 0; end
            else m_cnt++;
        end
        m_run = nrun; m_side = nside; m_pbw = cfg_bw; m_pts = cfg_test_sel;
    endtask

    task automatic compare_all();
        bit e;
        e = m_ovwr | m_mflg | m_acc | m_drng;
        chk("R1 error bit", {23'd0, status[23]}, {23'd0, e});
        chk("R1 error pin", {23'd0, err_n}, {23'd0, !e});
        chk("R2 overwrite", {23'd0, status[22]}, {23'd0, m_ovwr});
        chk("R3 modflag", {23'd0, status[21]}, {23'd0, m_mflg});
        chk("R4 acc", {23'd0, status[19]}, {23'd0, m_acc});
        chk("R5 range", {23'd0, status[16]}, {23'd0, m_drng});
        chk("R6 settled", {23'd0, status[17]}, {23'd0, (m_st == 1)});
        chk("R9 pending", {23'd0, status[18]}, {23'd0, m_pend});
        chk("R10 echo", {status[20], status[15:0]},
            {1'b0, 4'b0, cfg_pwrdn, cfg_test_sel, 1'b0, cfg_bw, 1'b0, cfg_gain});
    endtask

    always @(posedge clk) begin
        model_step();
        #2;
        compare_all();
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(bit st, bit rs, bit rd, bit mf, bit ac, bit sy);
        stat_rd_done = st; read_start = rs; read_done = rd;
        mod_flag = mf; acc_sat = ac; sync_req = sy;
        @(negedge clk);
        stat_rd_done = 0; read_start = 0; read_done = 0;
        mod_flag = 0; acc_sat = 0; sync_req = 0;
    endtask

    task automatic load_word(logic [23:0] s, bit rd);
        result_load = 1; sample = s;
        @(negedge clk);
        result_load = 0; sample = '0;
        if (rd) begin
            pulse(0, 1, 0, 0, 0, 0);
            pulse(0, 0, 1, 0, 0, 0);
        end
    endtask

    task automatic fill(int n);
        for (int i = 0; i < n; i++) load_word(24'h000100, 1);
    endtask

    localparam logic [23:0] V_HI = 24'h600000, V_HIEDGE = 24'h5FFFFF;
    localparam logic [23:0] V_LO = 24'h9FFFFF, V_LOEDGE = 24'hA00000;

    initial begin
        idle(3);
        rst_n = 1;
        idle(2);
        chk("R8 reset flags clear", {8'd0, status[23:16]}, 24'd0);
        chk("R10 reset echo", {12'd0, status[11:0]}, {12'd0, 12'b0000_1001_0110});
        chk("R1 reset pin high", {23'd0, err_n}, 24'd1);

        fill(SETTLE - 1);
        chk("R6 not settled after 15", {23'd0, status[17]}, 24'd0);
        fill(1);
        chk("R6 settled after 16", {23'd0, status[17]}, 24'd1);

        load_word(24'h000010, 0);
        chk("R9 pending set", {23'd0, status[18]}, 24'd1);
        load_word(24'h000011, 0);
        chk("R2 overwrite unread", {23'd0, status[22]}, 24'd1);
        chk("R1 pin low", {23'd0, err_n}, 24'd0);
        pulse(0, 0, 1, 0, 0, 0);
        chk("R9 pending cleared", {23'd0, status[18]}, 24'd0);
        pulse(1, 0, 0, 0, 0, 0);
        chk("R8 status read clears", {23'd0, status[22]}, 24'd0);
        chk("R1 pin high again", {23'd0, err_n}, 24'd1);

        pulse(0, 1, 0, 0, 0, 0);
        load_word(24'h000012, 0);
        chk("R2 overwrite partial read", {23'd0, status[22]}, 24'd1);
        pulse(0, 0, 1, 0, 0, 0);
        pulse(1, 0, 0, 0, 0, 0);
        load_word(24'h000013, 1);
        load_word(24'h000014, 1);
        chk("R2 no overwrite after read", {23'd0, status[22]}, 24'd0);

        pulse(0, 0, 0, 1, 0, 0);
        chk("R3 modflag set", {23'd0, status[21]}, 24'd1);
        pulse(1, 0, 0, 1, 0, 0);
        chk("R8 set wins over clear", {23'd0, status[21]}, 24'd1);
        pulse(1, 0, 0, 0, 0, 0);
        chk("R8 modflag cleared", {23'd0, status[21]}, 24'd0);

        pulse(0, 0, 0, 0, 1, 0);
        chk("R4 acc set", {23'd0, status[19]}, 24'd1);
        pulse(1, 0, 0, 0, 0, 0);
        chk("R8 acc cleared", {23'd0, status[19]}, 24'd0);

        for (int i = 0; i < 4; i++) load_word(V_HIEDGE, 1);
        for (int i = 0; i < 4; i++) load_word(V_LOEDGE, 1);
        chk("R5 limits are in range", {23'd0, status[16]}, 24'd0);
        for (int i = 0; i < 3; i++) load_word(V_HI, 1);
        load_word(24'h0, 1);
        for (int i = 0; i < 3; i++) load_word(V_HI, 1);
        chk("R5 broken run", {23'd0, status[16]}, 24'd0);
        for (int i = 0; i < 3; i++) load_word(V_LO, 1);
        chk("R5 sign change restarts", {23'd0, status[16]}, 24'd0);
        load_word(V_LO, 1);
        chk("R5 four low samples", {23'd0, status[16]}, 24'd1);
        pulse(1, 0, 0, 0, 0, 0);
        chk("R8 range cleared", {23'd0, status[16]}, 24'd0);

        pulse(0, 0, 0, 0, 1, 0);
        pulse(0, 0, 0, 0, 0, 1);
        chk("R6 sync unsettles", {23'd0, status[17]}, 24'd0);
        pulse(1, 0, 0, 0, 0, 0);
        chk("R7 clear frozen", {23'd0, status[19]}, 24'd1);
        pulse(0, 0, 0, 1, 1, 0);
        chk("R7 set frozen", {23'd0, status[21]}, 24'd0);
        fill(SETTLE);
        chk("R6 resettled after sync", {23'd0, status[17]}, 24'd1);
        pulse(1, 0, 0, 0, 0, 0);
        chk("R8 clear after settle", {23'd0, status[19]}, 24'd0);

        cfg_bw = 3'b011;
        idle(1);
        chk("R6 bw change unsettles", {23'd0, status[17]}, 24'd0);
        chk("R10 bw echo", {21'd0, status[8:6]}, 24'd3);
        fill(SETTLE);
        chk("R6 settled after bw", {23'd0, status[17]}, 24'd1);
        cfg_test_sel = 1;
        idle(1);
        chk("R6 test select unsettles", {23'd0, status[17]}, 24'd0);
        chk("R10 test select echo", {23'd0, status[10]}, 24'd1);
        fill(SETTLE);

        cfg_pwrdn = 1;
        idle(1);
        chk("R6 power-down unsettles", {23'd0, status[17]}, 24'd0);
        chk("R10 power-down echo", {23'd0, status[11]}, 24'd1);
        fill(SETTLE);
        pulse(0, 0, 0, 1, 0, 0);
        chk("R3 no set in power-down", {23'd0, status[21]}, 24'd0);
        chk("R6 loads ignored in power-down", {23'd0, status[17]}, 24'd0);
        cfg_pwrdn = 0;
        idle(1);
        fill(SETTLE - 1);
        chk("R6 not yet after power-down", {23'd0, status[17]}, 24'd0);
        fill(1);
        chk("R6 settled after power-down", {23'd0, status[17]}, 24'd1);

        pulse(0, 0, 0, 0, 1, 0);
        rst_n = 0;
        idle(2);
        chk("R8 reset clears acc", {8'd0, status[23:16]}, 24'd0);
        rst_n = 1;
        idle(3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule